// File: doc/BRIEF.md
# Detector Section Power-Up Sequencer

This block walks one detector section through a fixed power-on order. It starts from a safe idle state. It confirms the opto-board temperature, then turns on opto-board cooling and then opto-board power. Once that supply is good and drawing current in range, it checks the module and end-of-stave temperatures. It then turns on module cooling, and after that the combined end-of-stave-controller and module power. When the module supply is good and in range, it asks for opto-board initialization and waits for it to finish. It then asks for module configuration, and takes the module current being in range as proof that the configuration worked. At that point it reports readiness for tuning and data taking.

Each step that waits on an external flag has a timeout taken from the `tmo_limit` input. An expired wait, an interlock, or a loss of supply current while ready moves the sequencer to a fault state. On entry to that state the power enables drop at once, the cooling enables drop one cycle later, and a code naming the cause is held. Only an explicit restart request, given while the interlock is clear, brings the sequencer back to idle. The current step number is always visible on a 4-bit status output.

Top module: `det_pwrup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequencer goes to idle: `status` = 0, `err_code` = 0, and every enable, request and `ready` output is low.
- R2: Idle is left only at an edge where `start` is high and `interlock` is low, and it goes to status 1 (opto temperature check). An edge with `start` low keeps status 0.
- R3: The status code is one of: 1 opto temperature check, 2 opto cooling, 3 opto power, 4 module temperature check, 5 module cooling, 6 module power, 7 opto init, 8 module config, 9 ready, 15 fault. `opto_cool_en` is high exactly in codes 2 to 9. Code 1 moves to code 2 only at an edge where `opto_temp_ok` is high.
- R4: `opto_pwr_en` is high exactly in codes 3 to 9. Code 2 always moves to code 3 one cycle later, so opto power never comes on without opto cooling.
- R5: Code 3 moves to code 4 when `opto_pgood` and `opto_cur_ok` are both high. Code 4 moves to code 5 when `mod_temp_ok` and `eos_temp_ok` are both high. Code 5 always moves to code 6. `mod_cool_en` is high in codes 5 to 9 and `mod_pwr_en` is high in codes 6 to 9.
- R6: Code 6 moves to code 7 when `mod_pgood` and `mod_cur_ok` are both high. Code 7 drives `init_req` and moves to code 8 on `init_done`. Code 8 drives `cfg_req` and moves to code 9 when `cfg_done` and `mod_cur_ok` are both high. `ready` is high only in code 9.
- R7: The waiting codes are 1, 3, 4, 6, 7 and 8. If a waiting code's condition stays false at `tmo_limit`+1 edges in a row after entry, the sequencer goes to fault with `err_code` equal to that waiting code. If the condition is true at the edge where the timeout expires, the sequencer advances instead.
- R8: At any edge where `interlock` is high and the state is not fault, the next state is fault (15) with `err_code` = 14, and both power enables are low from that edge on.
- R9: On any entry into fault, a cooling enable that was high stays high for one more cycle and is low from the following edge on.
- R10: Fault is left only at an edge with `restart` high and `interlock` low. It goes to idle (code 0) and clears `err_code` to 0. A restart while the interlock is high has no effect.
- R11: In code 9, an edge where `opto_cur_ok` or `mod_cur_ok` is low moves the sequencer to fault with `err_code` = 13.
- R12: `status` always equals the current state code listed in R3, and it changes at the same edge as the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interlock | input | 1 | Temperature interlock active |
| start | input | 1 | Begin the power-up order from idle |
| restart | input | 1 | Leave the fault state |
| tmo_limit | input | TMO_W | Timeout limit for waiting steps |
| opto_temp_ok | input | 1 | Opto-board temperature within limits |
| mod_temp_ok | input | 1 | Module temperature within limits |
| eos_temp_ok | input | 1 | End-of-stave temperature within limits |
| opto_pgood | input | 1 | Opto-board supply good |
| opto_cur_ok | input | 1 | Opto-board current in range |
| mod_pgood | input | 1 | Module / end-of-stave supply good |
| mod_cur_ok | input | 1 | Module current in range |
| init_done | input | 1 | Opto-board initialization finished |
| cfg_done | input | 1 | Module configuration finished |
| opto_cool_en | output | 1 | Opto-board cooling enable |
| opto_pwr_en | output | 1 | Opto-board power enable |
| mod_cool_en | output | 1 | Module cooling enable |
| mod_pwr_en | output | 1 | End-of-stave controller and module power enable |
| init_req | output | 1 | Opto-board initialization request |
| cfg_req | output | 1 | Module configuration request |
| ready | output | 1 | Ready for tuning and data taking |
| status | output | 4 | Current state code |
| err_code | output | 4 | Cause of the last fault |

## Verification
Two things can fall due in the same cycle: a step's timeout can expire at the very edge where its awaited condition arrives, and an interlock can arrive at the edge where a step would otherwise advance. The bench provokes the first directly. It sets the limit to zero and raises the condition on the first edge of the wait, then expects the step to advance rather than fault. The random phase keeps limits small and interlocks rare but present, so both collisions recur many times. Every cycle is judged against a bench model of the order, the timer and the fault priority, in which interlock beats completion and completion beats timeout.

// File: rtl/pwrseq_pkg.sv
// Package pwrseq_pkg
// Shared state codes, fault codes and small helpers for the power-up
// sequencer. The numeric state values appear on the status port, so they
// are fixed here and must not be reordered.
package pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_OPTO_TCHK = 4'd1,
        ST_OPTO_COOL = 4'd2,
        ST_OPTO_PWR  = 4'd3,
        ST_MOD_TCHK  = 4'd4,
        ST_MOD_COOL  = 4'd5,
        ST_MOD_PWR   = 4'd6,
        ST_OPTO_INIT = 4'd7,
        ST_MOD_CFG   = 4'd8,
        ST_READY     = 4'd9,
        ST_FAULT     = 4'd15
    } seq_state_e;

    localparam logic [3:0] ERR_NONE = 4'd0;
    localparam logic [3:0] ERR_CURR = 4'd13;
    localparam logic [3:0] ERR_ILK  = 4'd14;

    // True when the state waits on an external condition under a timeout.
    function automatic logic is_wait_state(input seq_state_e s);
        return (s == ST_OPTO_TCHK) || (s == ST_OPTO_PWR) ||
               (s == ST_MOD_TCHK)  || (s == ST_MOD_PWR)  ||
               (s == ST_OPTO_INIT) || (s == ST_MOD_CFG);
    endfunction

    // True when the state code lies within [lo, hi].
    function automatic logic state_in(input seq_state_e s,
                                      input seq_state_e lo,
                                      input seq_state_e hi);
        return (s >= lo) && (s <= hi);
    endfunction

endpackage

// File: rtl/pwrseq_step_timer.sv
// Module pwrseq_step_timer
// Counts the cycles spent in one waiting step. It is cleared whenever the
// sequencer changes state and counts only while run is high. expired rises
// once the count reaches the limit. Assumes the limit is stable during a
// wait; if it is lowered below the count, expiry follows at once.
module pwrseq_step_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_q;

    // Count up while waiting, stop at the limit, restart on a state change.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (clear)              cnt_q <= '0;
        else if (run && cnt_q < limit) cnt_q <= cnt_q + 1'b1;
    end

    // Flag expiry only in a waiting step.
    always_comb expired = run && (cnt_q >= limit);

endmodule

// File: rtl/pwrseq_out_decode.sv
// Module pwrseq_out_decode
// Turns the state code into the enable, request and ready outputs. When
// the fault state is entered, power goes off at once, but each cooling
// enable that was on stays on for one extra cycle. Assumes the state input
// is the registered state of the sequencer.
module pwrseq_out_decode
    import pwrseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state_q,
    output logic       opto_cool_en,
    output logic       opto_pwr_en,
    output logic       mod_cool_en,
    output logic       mod_pwr_en,
    output logic       init_req,
    output logic       cfg_req,
    output logic       ready
);

    seq_state_e prev_q;
    logic       fault_first;

    // Remember last cycle's state so cooling can trail power on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= ST_IDLE;
        else        prev_q <= state_q;
    end

    // First cycle of a fault: the state is fault but was not one cycle ago.
    always_comb fault_first = (state_q == ST_FAULT) && (prev_q != ST_FAULT);

    // Map the state to the outputs, with the one-cycle cooling hold.
    always_comb begin
        opto_pwr_en  = state_in(state_q, ST_OPTO_PWR, ST_READY);
        mod_pwr_en   = state_in(state_q, ST_MOD_PWR, ST_READY);
        opto_cool_en = state_in(state_q, ST_OPTO_COOL, ST_READY) ||
                       (fault_first && state_in(prev_q, ST_OPTO_COOL, ST_READY));
        mod_cool_en  = state_in(state_q, ST_MOD_COOL, ST_READY) ||
                       (fault_first && state_in(prev_q, ST_MOD_COOL, ST_READY));
        init_req     = (state_q == ST_OPTO_INIT);
        cfg_req      = (state_q == ST_MOD_CFG);
        ready        = (state_q == ST_READY);
    end

    AST_OPTO_PWR_NEEDS_COOL: assert property (@(posedge clk) disable iff (!rst_n)
        opto_pwr_en |-> opto_cool_en); // R4
    AST_MOD_PWR_NEEDS_COOL: assert property (@(posedge clk) disable iff (!rst_n)
        mod_pwr_en |-> (mod_cool_en && opto_pwr_en)); // R5
    AST_COOL_TRAILS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_FAULT) |=> (!opto_cool_en && !mod_cool_en)); // R9
    AST_ONE_PHASE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_req, cfg_req, ready})); // R6

endmodule

// File: rtl/det_pwrup_seq.sv
// Module det_pwrup_seq
// Top of the power-up sequencer. It holds the state register and the next
// state logic, which applies the fixed step order, the interlock, the step
// timeouts and the fault exit. It records a fault code and shows the state
// on status. Assumes all flag inputs are already synchronous to clk.
module det_pwrup_seq
    import pwrseq_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             interlock,
    input  logic             start,
    input  logic             restart,
    input  logic [TMO_W-1:0] tmo_limit,
    input  logic             opto_temp_ok,
    input  logic             mod_temp_ok,
    input  logic             eos_temp_ok,
    input  logic             opto_pgood,
    input  logic             opto_cur_ok,
    input  logic             mod_pgood,
    input  logic             mod_cur_ok,
    input  logic             init_done,
    input  logic             cfg_done,
    output logic             opto_cool_en,
    output logic             opto_pwr_en,
    output logic             mod_cool_en,
    output logic             mod_pwr_en,
    output logic             init_req,
    output logic             cfg_req,
    output logic             ready,
    output logic [3:0]       status,
    output logic [3:0]       err_code
);

    seq_state_e state_q, state_d;
    logic [3:0] err_q, err_d;
    logic       step_ok;
    logic       tmo_expired;

    // Condition each waiting step is waiting for.
    always_comb begin
        case (state_q)
            ST_OPTO_TCHK: step_ok = opto_temp_ok;
            ST_OPTO_PWR:  step_ok = opto_pgood && opto_cur_ok;
            ST_MOD_TCHK:  step_ok = mod_temp_ok && eos_temp_ok;
            ST_MOD_PWR:   step_ok = mod_pgood && mod_cur_ok;
            ST_OPTO_INIT: step_ok = init_done;
            ST_MOD_CFG:   step_ok = cfg_done && mod_cur_ok;
            default:      step_ok = 1'b0;
        endcase
    end

    // Next state and fault code: interlock first, then completion, then timeout.
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        if (state_q == ST_FAULT) begin
            if (restart && !interlock) begin
                state_d = ST_IDLE;
                err_d   = ERR_NONE;
            end
        end else if (interlock) begin
            state_d = ST_FAULT;
            err_d   = ERR_ILK;
        end else begin
            case (state_q)
                ST_IDLE:      if (start) state_d = ST_OPTO_TCHK;
                ST_OPTO_COOL: state_d = ST_OPTO_PWR;
                ST_MOD_COOL:  state_d = ST_MOD_PWR;
                ST_READY: begin
                    if (!opto_cur_ok || !mod_cur_ok) begin
                        state_d = ST_FAULT;
                        err_d   = ERR_CURR;
                    end
                end
                ST_OPTO_TCHK, ST_OPTO_PWR, ST_MOD_TCHK,
                ST_MOD_PWR, ST_OPTO_INIT, ST_MOD_CFG: begin
                    if (step_ok) begin
                        state_d = seq_state_e'(state_q + 4'd1);
                    end else if (tmo_expired) begin
                        state_d = ST_FAULT;
                        err_d   = state_q;
                    end
                end
                default: begin
                    state_d = ST_FAULT;
                    err_d   = ERR_ILK;
                end
            endcase
        end
    end

    // State and fault code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            err_q   <= ERR_NONE;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
        end
    end

    pwrseq_step_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_d != state_q),
        .run     (is_wait_state(state_q)),
        .limit   (tmo_limit),
        .expired (tmo_expired)
    );

    pwrseq_out_decode u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_q      (state_q),
        .opto_cool_en (opto_cool_en),
        .opto_pwr_en  (opto_pwr_en),
        .mod_cool_en  (mod_cool_en),
        .mod_pwr_en   (mod_pwr_en),
        .init_req     (init_req),
        .cfg_req      (cfg_req),
        .ready        (ready)
    );

    // Present the state and fault code.
    always_comb begin
        status   = state_q;
        err_code = err_q;
    end

    AST_ILK_KILLS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        interlock |=> (!opto_pwr_en && !mod_pwr_en && status == 4'd15)); // R8
    AST_FAULT_EXIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 4'd0 && $past(status) == 4'd15) |-> $past(restart && !interlock)); // R10
    AST_IDLE_LEAVES_TO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status) == 4'd0 && status != 4'd0) |-> (status == 4'd1 || status == 4'd15)); // R2
    AST_READY_CURRENT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !mod_cur_ok && !interlock) |=> (status == 4'd15 && err_code == 4'd13)); // R11

endmodule

// File: tb/tb_det_pwrup_seq.sv
// Bench for det_pwrup_seq: directed corner cases, then seeded random
// stimulus, all compared each cycle with a bench model of the requirements.
module tb_det_pwrup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int TMO_W      = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic interlock = 0, start = 0, restart = 0;
    logic [TMO_W-1:0] tmo_limit = '0;
    logic opto_temp_ok = 0, mod_temp_ok = 0, eos_temp_ok = 0;
    logic opto_pgood = 0, opto_cur_ok = 0, mod_pgood = 0, mod_cur_ok = 0;
    logic init_done = 0, cfg_done = 0;
    logic opto_cool_en, opto_pwr_en, mod_cool_en, mod_pwr_en;
    logic init_req, cfg_req, ready;
    logic [3:0] status, err_code;

    int total = 0;
    int bad = 0;

    int m_state, m_prev, m_err, m_cnt;
    int n_state, n_err, n_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    det_pwrup_seq #(.TMO_W(TMO_W)) dut (
        .clk(clk), .rst_n(rst_n), .interlock(interlock), .start(start),
        .restart(restart), .tmo_limit(tmo_limit),
        .opto_temp_ok(opto_temp_ok), .mod_temp_ok(mod_temp_ok),
        .eos_temp_ok(eos_temp_ok), .opto_pgood(opto_pgood),
        .opto_cur_ok(opto_cur_ok), .mod_pgood(mod_pgood),
        .mod_cur_ok(mod_cur_ok), .init_done(init_done), .cfg_done(cfg_done),
        .opto_cool_en(opto_cool_en), .opto_pwr_en(opto_pwr_en),
        .mod_cool_en(mod_cool_en), .mod_pwr_en(mod_pwr_en),
        .init_req(init_req), .cfg_req(cfg_req), .ready(ready),
        .status(status), .err_code(err_code)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, got, exp, $time);
        end
    endtask

    function automatic bit in_rng(input int s, input int lo, input int hi);
        return (s >= lo) && (s <= hi);
    endfunction

    function automatic bit exp_cool(input int s, input int p, input int lo);
        return in_rng(s, lo, 9) || (s == 15 && p != 15 && in_rng(p, lo, 9));
    endfunction

    function automatic bit is_wait(input int s);
        return s == 1 || s == 3 || s == 4 || s == 6 || s == 7 || s == 8;
    endfunction

    function automatic bit cond_of(input int s);
        case (s)
            1: return opto_temp_ok;
            3: return opto_pgood && opto_cur_ok;
            4: return mod_temp_ok && eos_temp_ok;
            6: return mod_pgood && mod_cur_ok;
            7: return init_done;
            8: return cfg_done && mod_cur_ok;
            default: return 1'b0;
        endcase
    endfunction

    // Next model state from the requirements (R2 to R11).
    task automatic model_step();
        n_state = m_state;
        n_err   = m_err;
        if (m_state == 15) begin
            if (restart && !interlock) begin n_state = 0; n_err = 0; end
        end else if (interlock) begin
            n_state = 15; n_err = 14;
        end else if (m_state == 0) begin
            if (start) n_state = 1;
        end else if (m_state == 2 || m_state == 5) begin
            n_state = m_state + 1;
        end else if (m_state == 9) begin
            if (!opto_cur_ok || !mod_cur_ok) begin n_state = 15; n_err = 13; end
        end else if (cond_of(m_state)) begin
            n_state = m_state + 1;
        end else if (m_cnt >= int'(tmo_limit)) begin
            n_state = 15; n_err = m_state;
        end
        if (n_state != m_state) n_cnt = 0;
        else if (is_wait(m_state) && m_cnt < int'(tmo_limit)) n_cnt = m_cnt + 1;
        else n_cnt = m_cnt;
    endtask

    task automatic check_all();
        chk("R12 status", status, m_state);
        chk("R7 err_code", err_code, m_err);
        chk("R3 opto_cool_en", opto_cool_en, exp_cool(m_state, m_prev, 2));
        chk("R4 opto_pwr_en", opto_pwr_en, in_rng(m_state, 3, 9));
        chk("R5 mod_cool_en", mod_cool_en, exp_cool(m_state, m_prev, 5));
        chk("R5 mod_pwr_en", mod_pwr_en, in_rng(m_state, 6, 9));
        chk("R6 init_req", init_req, m_state == 7);
        chk("R6 cfg_req", cfg_req, m_state == 8);
        chk("R6 ready", ready, m_state == 9);
    endtask

    // One clock: predict, let the edge pass, then compare away from the edge.
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        m_prev  = m_state;
        m_state = n_state;
        m_err   = n_err;
        m_cnt   = n_cnt;
        check_all();
    endtask

    task automatic all_good();
        interlock = 0; start = 0; restart = 0;
        opto_temp_ok = 1; mod_temp_ok = 1; eos_temp_ok = 1;
        opto_pgood = 1; opto_cur_ok = 1; mod_pgood = 1; mod_cur_ok = 1;
        init_done = 1; cfg_done = 1;
    endtask

    task automatic do_restart();
        all_good(); restart = 1; tick(); restart = 0;
        chk("R10 back to idle", status, 0);
    endtask

    task automatic run_to_ready();
        all_good(); start = 1; tick(); start = 0;
        for (int i = 0; i < 9; i++) tick();
        chk("R6 ready reached", ready, 1);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 0;
        repeat (3) @(negedge clk);
        m_state = 0; m_prev = 0; m_err = 0; m_cnt = 0;
        check_all();
        chk("R1 reset status", status, 0);
        rst_n = 1;

        // R2: no start keeps idle; start with interlock goes to fault.
        all_good(); tmo_limit = 4;
        tick(); tick();
        chk("R2 idle held", status, 0);
        interlock = 1; start = 1; tick();
        chk("R2 start blocked by interlock", status, 15);
        chk("R8 interlock code", err_code, 14);
        start = 0; restart = 1; tick();
        chk("R10 restart ignored under interlock", status, 15);
        do_restart();
        chk("R10 code cleared", err_code, 0);

        // R7: timeout in the opto temperature check.
        tmo_limit = 2; start = 1; tick(); start = 0;
        opto_temp_ok = 0;
        tick(); tick();
        chk("R7 still waiting", status, 1);
        chk("R3 no cooling before temp ok", opto_cool_en, 0);
        tick();
        chk("R7 timeout fault", status, 15);
        chk("R7 timeout code", err_code, 1);
        do_restart();

        // R7: completion on the expiry edge wins (limit zero).
        tmo_limit = 0; start = 1; tick(); start = 0;
        tick();
        chk("R7 completion beats expiry", status, 2);
        chk("R3 opto cooling on", opto_cool_en, 1);
        interlock = 1; tick(); interlock = 0;
        tick(); do_restart();

        // R8/R9: interlock while ready.
        tmo_limit = 5; run_to_ready();
        interlock = 1; tick();
        chk("R8 opto power off", opto_pwr_en, 0);
        chk("R8 module power off", mod_pwr_en, 0);
        chk("R9 opto cooling held one cycle", opto_cool_en, 1);
        chk("R9 module cooling held one cycle", mod_cool_en, 1);
        tick();
        chk("R9 opto cooling off", opto_cool_en, 0);
        chk("R9 module cooling off", mod_cool_en, 0);
        do_restart();

        // R11: current loss while ready.
        run_to_ready();
        mod_cur_ok = 0; tick();
        chk("R11 current fault", status, 15);
        chk("R11 current code", err_code, 13);
        do_restart();

        // Random phase.
        for (int blk = 0; blk < 20; blk++) begin
            tmo_limit = TMO_W'($urandom_range(0, 5));
            for (int c = 0; c < 200; c++) begin
                interlock    = ($urandom_range(0, 99) == 0);
                start        = ($urandom_range(0, 3) == 0);
                restart      = ($urandom_range(0, 7) == 0);
                opto_temp_ok = ($urandom_range(0, 7) != 0);
                mod_temp_ok  = ($urandom_range(0, 7) != 0);
                eos_temp_ok  = ($urandom_range(0, 7) != 0);
                opto_pgood   = ($urandom_range(0, 7) != 0);
                opto_cur_ok  = ($urandom_range(0, 15) != 0);
                mod_pgood    = ($urandom_range(0, 7) != 0);
                mod_cur_ok   = ($urandom_range(0, 15) != 0);
                init_done    = ($urandom_range(0, 2) == 0);
                cfg_done     = ($urandom_range(0, 2) == 0);
                tick();
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule